// File: doc/BRIEF.md
# Virtual Machine Integer ALU

This block is the integer execution unit of a 64-bit virtual machine. Each cycle it may accept one operation: a 4-bit operation code, a width flag and two 64-bit operands A and B. One clock later it presents the 64-bit result C with a valid strobe. The unit never stalls, so a new operation can enter on every cycle.

The operation set covers 64-bit and 32-bit add and subtract, and AND, OR and XOR at both widths. It has five multiplies: the low half of a 64x64 product, the unsigned high half, the signed high half, and unsigned and signed 32x32 products that fill all 64 bits. It also has left shift, logical and arithmetic right shift, and both rotate directions. Every shift and rotate takes its amount from the low 6 bits of B.

The output side is a two-state machine. State `ST_EMPTY` means no result is presented. State `ST_FULL` means a fresh result is on the port. From either state, the next state is `ST_FULL` when `in_valid` is high and `ST_EMPTY` when it is low. Reset enters `ST_EMPTY`.

Top module: `vm_int_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. After reset, `out_valid` is 0 and `result` is 0.
- R2: Operation code 0 gives A+B and code 1 gives A-B, both modulo 2^64. When `narrow`=1, only bits 31:0 of each operand are used and `result[63:32]` is 0.
- R3: Code 2 gives A&B, code 3 gives A|B and code 4 gives A^B. When `narrow`=1, only bits 31:0 of each operand are used and `result[63:32]` is 0.
- R4: Code 5 gives the low 64 bits of A*B.
- R5: Code 6 gives the upper 64 bits of the unsigned 128-bit product of A and B. Code 7 gives the upper 64 bits of the signed 128-bit product.
- R6: Code 8 gives the full 64-bit unsigned product of A[31:0] and B[31:0]. Code 9 gives the full 64-bit signed product of the same two fields.
- R7: Code 10 shifts A left, code 11 shifts A right logically, and code 12 shifts A right arithmetically with A taken as signed. The amount is B[5:0], and B[63:6] has no effect.
- R8: Code 13 rotates A left and code 14 rotates A right, by B[5:0]. A rotate by 0 returns A.
- R9: Code 15 gives C = A.
- R10: For codes 5 to 15, `narrow` has no effect on the result.
- R11: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| narrow | input | 1 | 32-bit form for add, subtract and logic ops |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | Result C |

## Verification
A result register that captures on the wrong cycle, or a state register stuck in `ST_FULL`, shows at the ports one cycle after the operation that exposes it. It appears as a stale `result` or a valid strobe with no matching input. A wrong operand field inside a unit shows on the first vector that uses that code with nonzero upper bits. Examples are a missing 32-bit mask, a multiply that is not sign-extended, or a shift amount wider than 6 bits. The bench therefore feeds all-ones operands, most-negative operands and B values with garbage above bit 5.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_AND    = 4'd2,
        OP_OR     = 4'd3,
        OP_XOR    = 4'd4,
        OP_MULLO  = 4'd5,
        OP_MULHU  = 4'd6,
        OP_MULHS  = 4'd7,
        OP_MULU32 = 4'd8,
        OP_MULS32 = 4'd9,
        OP_SHL    = 4'd10,
        OP_SHR    = 4'd11,
        OP_SAR    = 4'd12,
        OP_ROL    = 4'd13,
        OP_ROR    = 4'd14,
        OP_PASS   = 4'd15
    } alu_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/vm_alu_arith.sv
module vm_alu_arith
    import vm_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  alu_op_e          op,
    input  logic             narrow,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  res
);
    localparam int UPPER = XLEN - NARROW;

    logic [XLEN-1:0] keep;
    logic [XLEN-1:0] am;
    logic [XLEN-1:0] bm;
    logic [XLEN-1:0] raw;

    assign keep = {{UPPER{~narrow}}, {NARROW{1'b1}}};
    assign am   = a & keep;
    assign bm   = b & keep;

    always_comb begin
        unique case (op)
            OP_ADD:  raw = am + bm;
            OP_SUB:  raw = am - bm;
            OP_AND:  raw = am & bm;
            OP_OR:   raw = am | bm;
            OP_XOR:  raw = am ^ bm;
            default: raw = '0;
        endcase
    end

    assign res = raw & keep;
endmodule

// File: rtl/vm_alu_mul.sv
module vm_alu_mul
    import vm_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  res
);
    localparam int UPPER = XLEN - NARROW;
    localparam int PW    = 2 * XLEN;

    logic [PW-1:0]   prod_u;
    logic [PW-1:0]   prod_s;
    logic [XLEN-1:0] prod_nu;
    logic [XLEN-1:0] prod_ns;

    assign prod_u  = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    assign prod_s  = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{b[XLEN-1]}}, b};
    assign prod_nu = {{UPPER{1'b0}}, a[NARROW-1:0]} * {{UPPER{1'b0}}, b[NARROW-1:0]};
    assign prod_ns = {{UPPER{a[NARROW-1]}}, a[NARROW-1:0]}
                   * {{UPPER{b[NARROW-1]}}, b[NARROW-1:0]};

    always_comb begin
        unique case (op)
            OP_MULLO:  res = prod_u[XLEN-1:0];
            OP_MULHU:  res = prod_u[PW-1:XLEN];
            OP_MULHS:  res = prod_s[PW-1:XLEN];
            OP_MULU32: res = prod_nu;
            OP_MULS32: res = prod_ns;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/vm_alu_shift.sv
module vm_alu_shift
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  res
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] amt;
    logic [SHW:0]   inv;

    assign amt = b[SHW-1:0];
    assign inv = (SHW+1)'(XLEN) - {1'b0, amt};

    always_comb begin
        unique case (op)
            OP_SHL:  res = a << amt;
            OP_SHR:  res = a >> amt;
            OP_SAR:  res = $unsigned($signed(a) >>> amt);
            OP_ROL:  res = (a << amt) | (a >> inv);
            OP_ROR:  res = (a >> amt) | (a << inv);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
    import vm_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32,
    parameter int OPW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   op,
    input  logic             narrow,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic             out_valid,
    output logic [XLEN-1:0]  result
);
    alu_op_e         op_e;
    out_state_e      state_q;
    out_state_e      state_d;
    logic [XLEN-1:0] arith_res;
    logic [XLEN-1:0] mul_res;
    logic [XLEN-1:0] shift_res;
    logic [XLEN-1:0] c_next;
    logic [XLEN-1:0] c_q;

    assign op_e = alu_op_e'(op);

    vm_alu_arith #(.XLEN(XLEN), .NARROW(NARROW)) u_arith (
        .op(op_e), .narrow(narrow), .a(a), .b(b), .res(arith_res)
    );

    vm_alu_mul #(.XLEN(XLEN), .NARROW(NARROW)) u_mul (
        .op(op_e), .a(a), .b(b), .res(mul_res)
    );

    vm_alu_shift #(.XLEN(XLEN)) u_shift (
        .op(op_e), .a(a), .b(b), .res(shift_res)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:           c_next = arith_res;
            OP_MULLO, OP_MULHU, OP_MULHS, OP_MULU32, OP_MULS32: c_next = mul_res;
            OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR:          c_next = shift_res;
            default:                                         c_next = a;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else if (in_valid) begin
            c_q <= c_next;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        result    = c_q;
    end
endmodule

// File: rtl/vm_int_alu_chk.sv
module vm_int_alu_chk #(
    parameter int XLEN   = 64,
    parameter int NARROW = 32,
    parameter int OPW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OPW-1:0]   op,
    input logic             narrow,
    input logic [XLEN-1:0]  a,
    input logic [XLEN-1:0]  b,
    input logic             out_valid,
    input logic [XLEN-1:0]  result
);
    localparam int SHW = $clog2(XLEN);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow && op <= OPW'(4)) |=> (result[XLEN-1:NARROW] == '0));

    assert_xor_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !narrow && op == OPW'(4)) |=> (result == ($past(a) ^ $past(b))));

    assert_rotate_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OPW'(13) || op == OPW'(14)) && b[SHW-1:0] == '0)
        |=> (result == $past(a)));

    assert_pass_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OPW'(15)) |=> (result == $past(a)));

    assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
endmodule

bind vm_int_alu vm_int_alu_chk #(.XLEN(XLEN), .NARROW(NARROW), .OPW(OPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
);

// File: tb/tb_vm_int_alu.sv
module tb_vm_int_alu;
    localparam int  NVEC = 18;
    localparam logic [63:0] ONES   = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINNEG = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        narrow = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vm_int_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
        .a(a), .b(b), .out_valid(out_valid), .result(result)
    );

    // stimulus table: {op, narrow, a, b}
    localparam logic [132:0] VEC [NVEC] = '{
        {4'd0,  1'b0, ONES, 64'd1},                                   // R2 wrap
        {4'd0,  1'b1, 64'h0000_0001_FFFF_FFFF, 64'h0000_0007_0000_0001}, // R2
        {4'd1,  1'b0, 64'd0, 64'd1},                                  // R2
        {4'd1,  1'b1, 64'hDEAD_0000_0000_0000, 64'd1},                // R2
        {4'd2,  1'b1, ONES, 64'h1234_5678_9ABC_DEF0},                 // R3
        {4'd3,  1'b0, MINNEG, 64'h0F0F_0F0F_0F0F_0F0F},               // R3
        {4'd4,  1'b1, ONES, 64'hAAAA_AAAA_5555_5555},                 // R3
        {4'd5,  1'b0, MINNEG, ONES},                                  // R4
        {4'd6,  1'b0, ONES, ONES},                                    // R5
        {4'd7,  1'b0, MINNEG, MINNEG},                                // R5
        {4'd8,  1'b0, 64'h1234_5678_FFFF_FFFF, 64'h9999_0000_FFFF_FFFF}, // R6
        {4'd9,  1'b0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF}, // R6
        {4'd10, 1'b0, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFC1}, // R7
        {4'd11, 1'b0, ONES, 64'h0000_0000_0000_013F},                 // R7
        {4'd12, 1'b0, MINNEG, 64'd63},                                // R7
        {4'd13, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h40},               // R8
        {4'd14, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd4},                // R8
        {4'd15, 1'b1, 64'hCAFE_F00D_1234_5678, ONES}                  // R9
    };

    function automatic logic [63:0] ref_model(input logic [3:0] o, input logic n,
                                              input logic [63:0] x, input logic [63:0] y);
        logic [63:0]         xm, ym, r;
        logic [127:0]        pu;
        logic signed [127:0] sx, sy, ps;
        logic signed [63:0]  nx, ny;
        int                  s;
        xm = n ? {32'd0, x[31:0]} : x;
        ym = n ? {32'd0, y[31:0]} : y;
        pu = 128'(x) * 128'(y);
        sx = 128'($signed(x));
        sy = 128'($signed(y));
        ps = sx * sy;
        nx = 64'($signed(x[31:0]));
        ny = 64'($signed(y[31:0]));
        s  = int'(y[5:0]);
        r  = x;
        case (o)
            4'd0:  r = xm + ym;
            4'd1:  r = xm - ym;
            4'd2:  r = xm & ym;
            4'd3:  r = xm | ym;
            4'd4:  r = xm ^ ym;
            4'd5:  r = pu[63:0];
            4'd6:  r = pu[127:64];
            4'd7:  r = ps[127:64];
            4'd8:  r = 64'(x[31:0]) * 64'(y[31:0]);
            4'd9:  r = 64'(nx * ny);
            4'd10: r = x << s;
            4'd11: r = x >> s;
            4'd12: begin
                for (int i = 0; i < 64; i++) r[i] = (i + s > 63) ? x[63] : x[i + s];
            end
            4'd13: begin
                for (int i = 0; i < 64; i++) r[(i + s) % 64] = x[i];
            end
            4'd14: begin
                for (int i = 0; i < 64; i++) r[i] = x[(i + s) % 64];
            end
            default: r = x;
        endcase
        if (n && o <= 4'd4) r[63:32] = '0;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic n, input logic [63:0] x,
                         input logic [63:0] y);
        op = o; narrow = n; a = x; b = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            issue(VEC[k][132:129], VEC[k][128], VEC[k][127:64], VEC[k][63:0]);
            check("R1 valid", {63'd0, out_valid}, 64'd1);
            check($sformatf("R%0s table op %0d", "2-9", VEC[k][132:129]), result,
                  ref_model(VEC[k][132:129], VEC[k][128], VEC[k][127:64], VEC[k][63:0]));
        end

        // directed known values
        issue(4'd6, 1'b0, ONES, ONES);
        check("R5 mulhu ones", result, 64'hFFFF_FFFF_FFFF_FFFE);
        issue(4'd7, 1'b0, MINNEG, MINNEG);
        check("R5 mulhs minneg", result, 64'h4000_0000_0000_0000);
        issue(4'd7, 1'b0, ONES, ONES);
        check("R5 mulhs minus one", result, 64'd0);
        issue(4'd9, 1'b0, 64'h1111_1111_FFFF_FFFF, 64'h2222_2222_FFFF_FFFF);
        check("R6 muls32 minus one", result, 64'd1);
        issue(4'd8, 1'b0, 64'h1111_1111_FFFF_FFFF, 64'h2222_2222_FFFF_FFFF);
        check("R6 mulu32 ones", result, 64'hFFFF_FFFE_0000_0001);
        issue(4'd12, 1'b0, MINNEG, 64'hFFFF_FFFF_FFFF_FF3F);
        check("R7 sar 63", result, ONES);
        issue(4'd4, 1'b0, ONES, 64'h0000_FFFF_0000_FFFF);
        check("R3 xor wide", result, 64'hFFFF_0000_FFFF_0000);
        issue(4'd1, 1'b1, 64'h5555_5555_0000_0000, 64'd1);
        check("R2 sub narrow", result, 64'h0000_0000_FFFF_FFFF);
        issue(4'd13, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFC0);
        check("R8 rol zero", result, 64'h0123_4567_89AB_CDEF);
        issue(4'd14, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd4);
        check("R8 ror 4", result, 64'hF012_3456_789A_BCDE);
        issue(4'd15, 1'b0, 64'hCAFE_F00D_1234_5678, 64'd0);
        check("R9 pass", result, 64'hCAFE_F00D_1234_5678);
        issue(4'd5, 1'b1, MINNEG | 64'd3, ONES);
        check("R10 narrow ignored mullo", result, ref_model(4'd5, 1'b0, MINNEG | 64'd3, ONES));
        issue(4'd11, 1'b1, ONES, 64'd8);
        check("R10 narrow ignored shr", result, 64'h00FF_FFFF_FFFF_FFFF);

        // hold while idle
        held = result;
        op = 4'd0; a = 64'd77; b = 64'd5; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R11 hold", result, held);

        // random sweep, back to back
        for (int k = 0; k < 300; k++) begin
            logic [3:0]  ro;
            logic        rn;
            logic [63:0] ra, rb;
            ro = 4'($urandom_range(0, 15));
            rn = 1'($urandom_range(0, 1));
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (k % 7 == 0) ra = MINNEG;
            if (k % 11 == 0) rb = ONES;
            issue(ro, rn, ra, rb);
            check($sformatf("R%0d random op %0d", (ro <= 1) ? 2 : 0, ro), result,
                  ref_model(ro, rn, ra, rb));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule